// File: doc/BRIEF.md
# RS485 Serial Transmitter with Driver-Enable Window

This block is the transmit half of a UART that drives a half-duplex RS485 line through an external transceiver. A writer hands over one data word at a time through a valid/ready port into a single holding slot. When the transmitter is enabled and the slot is full, the block raises the transceiver's driver-enable and waits a programmable lead time. It then shifts the frame out on the serial line. After the final stop bit it keeps driver-enable high for a programmable trail time, drops it, and pulses a completion flag.

Each bit lasts sixteen pulses of an externally generated oversampling tick. Both the lead time and the trail time are 5-bit counts of those same ticks. The frame carries 7, 8 or 9 data bits. When parity is on, the highest data position holds the parity bit, so the frame keeps the same length. A word that arrives while driver-enable is still held follows the previous frame directly, with no new lead time.

Top module: `rs485_tx`

## Requirements
- R1: The block drives the line only while `en_all` and `en_tx` are both high. If either is low at a clock edge, `de` is low and `txd` is high from the next cycle on, and any frame in progress is dropped without a `tx_done` pulse.
- R2: When `de` rises from idle, the start bit begins on tick number `lead_dly`+1 after the rise, so a value of 0 starts the frame on the first tick.
- R3: After the stop bit of the last queued frame ends, `de` stays high for `trail_dly` more ticks and falls on the tick after that.
- R4: Every bit on `txd` lasts exactly 16 ticks of `os_tick`.
- R5: `len_sel` picks the number of data bits: 00 gives 8, 01 gives 9 and 10 gives 7.
- R6: The code 11 on `len_sel` is ignored, and the last legal length stays in force.
- R7: With `par_on` high, data position N-1 (N = data bits) carries the parity of data bits 0..N-2 in place of that data bit, and the frame length does not change.
- R8: `par_odd` = 0 selects even parity, so the count of ones over the N data positions including parity is even. `par_odd` = 1 selects odd parity.
- R9: A frame is one start bit at 0, then data bits least significant first, then one stop bit at 1. `txd` is 1 whenever no frame is being shifted.
- R10: A word held in the slot when a stop bit ends is sent starting on the next tick, with no lead time and no drop of `de`.
- R11: `tx_done` is a one-cycle pulse in the first cycle after `de` falls at the end of the trail time.
- R12: The slot holds one word. `wr_ready` and `buf_empty` are high exactly when it is empty. A word is taken on a clock edge with `wr_valid` and `wr_ready` both high, and the slot empties when its frame starts shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| en_all | input | 1 | Global enable |
| en_tx | input | 1 | Transmitter enable |
| len_sel | input | 2 | Data length code |
| par_on | input | 1 | Parity insertion on |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| lead_dly | input | 5 | Ticks between `de` rising and the start bit |
| trail_dly | input | 5 | Ticks `de` is held after the last stop bit |
| wr_valid | input | 1 | Write request |
| wr_data | input | 9 | Word to send |
| wr_ready | output | 1 | Slot can take a word |
| txd | output | 1 | Serial line |
| de | output | 1 | Transceiver driver-enable |
| buf_empty | output | 1 | Holding slot empty |
| tx_done | output | 1 | Pulse after `de` is released |

## Verification
The bench runs every legal length with parity off, even and odd, and every pairing of lead and trail from 0, 1, 7 and 31. It compares `txd`, `de` and `tx_done` on every tick against a timeline it computes itself. A design with an off-by-one in either delay counter would shift the start bit or the release of `de` by one tick. A parity bit added after the data instead of replacing the top bit would lengthen the frame and move the stop bit. Back-to-back pairs would expose a lead time wrongly inserted between queued frames. A reserved length code, a transmitter held disabled with a word waiting, and an enable dropped mid-frame check that a bad code does not change the length, that nothing is driven while disabled, and that an aborted frame gives no completion pulse.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;

    localparam int unsigned WORD_W = 9;
    localparam int unsigned FRM_W  = WORD_W + 2;
    localparam int unsigned CNT_W  = $clog2(FRM_W + 1);

    typedef enum logic [1:0] {
        LEN_EIGHT = 2'b00,
        LEN_NINE  = 2'b01,
        LEN_SEVEN = 2'b10,
        LEN_RSVD  = 2'b11
    } len_sel_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LEAD,
        S_SHIFT,
        S_TRAIL
    } tx_state_e;

    typedef struct packed {
        logic [FRM_W-1:0] bits;   // bit 0 leaves first
        logic [CNT_W-1:0] nbits;  // start + data + stop
    } frame_t;

    function automatic logic [CNT_W-1:0] word_bits(input len_sel_e sel);
        case (sel)
            LEN_NINE:  return CNT_W'(9);
            LEN_SEVEN: return CNT_W'(7);
            default:   return CNT_W'(8);
        endcase
    endfunction

    // Build the serial image: start 0, data LSB first (top position
    // replaced by parity when enabled), stop 1, unused tail high.
    function automatic frame_t make_frame(input logic [WORD_W-1:0] d,
                                          input len_sel_e           sel,
                                          input logic               par_on,
                                          input logic               par_odd);
        frame_t           f;
        logic [CNT_W-1:0] n;
        logic             p;
        n       = word_bits(sel);
        p       = par_odd;
        f.bits  = '1;
        f.bits[0] = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            if (CNT_W'(i + 1) < n) p = p ^ d[i];
        end
        for (int i = 0; i < WORD_W; i++) begin
            if (CNT_W'(i) < n) begin
                f.bits[i+1] = (par_on && (CNT_W'(i + 1) == n)) ? p : d[i];
            end
        end
        f.nbits = n + CNT_W'(2);
        return f;
    endfunction

endpackage

// File: rtl/rs485_len_hold.sv
module rs485_len_hold
    import rs485_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel_in,
    output len_sel_e   sel_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= LEN_EIGHT;
        end else if (sel_in != 2'(LEN_RSVD)) begin
            sel_q <= len_sel_e'(sel_in);
        end
    end

    a_r6_rsvd_ignored: assert property (@(posedge clk) disable iff (rst)
        (sel_in == 2'b11) |=> $stable(sel_q));

    a_r5_legal_taken: assert property (@(posedge clk) disable iff (rst)
        (sel_in != 2'b11) |=> (2'(sel_q) == $past(sel_in)));

endmodule

// File: rtl/rs485_lag_count.sv
module rs485_lag_count #(
    parameter int unsigned DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [DLY_W-1:0] limit,
    output logic             hit
);

    logic [DLY_W-1:0] cnt;

    assign hit = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (step && !hit) begin
            cnt <= cnt + DLY_W'(1);
        end
    end

endmodule

// File: rtl/rs485_bit_shift.sv
module rs485_bit_shift
    import rs485_tx_pkg::*;
#(
    parameter int unsigned OS = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   load,
    input  frame_t frm,
    input  logic   tick,
    output logic   txd,
    output logic   frame_end
);

    localparam int unsigned SUB_W = $clog2(OS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OS - 1);

    logic [FRM_W-1:0] sh;
    logic [SUB_W-1:0] sub;
    logic [CNT_W-1:0] left;

    assign txd       = (left != '0) ? sh[0] : 1'b1;
    assign frame_end = tick && (left == CNT_W'(1)) && (sub == SUB_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh   <= '1;
            sub  <= '0;
            left <= '0;
        end else if (load) begin
            sh   <= frm.bits;
            sub  <= '0;
            left <= frm.nbits;
        end else if (tick && (left != '0)) begin
            if (sub == SUB_LAST) begin
                sub  <= '0;
                sh   <= {1'b1, sh[FRM_W-1:1]};
                left <= left - CNT_W'(1);
            end else begin
                sub <= sub + SUB_W'(1);
            end
        end
    end

    // R4: a bit cannot change before its sixteenth tick
    a_r4_bit_hold: assert property (@(posedge clk) disable iff (rst)
        ((left != '0) && tick && (sub != SUB_LAST) && !load && !clear)
        |=> $stable(txd));

endmodule

// File: rtl/rs485_tx.sv
module rs485_tx
    import rs485_tx_pkg::*;
#(
    parameter int unsigned DLY_W = 5,
    parameter int unsigned OS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  logic              en_all,
    input  logic              en_tx,
    input  logic [1:0]        len_sel,
    input  logic              par_on,
    input  logic              par_odd,
    input  logic [DLY_W-1:0]  lead_dly,
    input  logic [DLY_W-1:0]  trail_dly,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              txd,
    output logic              de,
    output logic              buf_empty,
    output logic              tx_done
);

    tx_state_e         state, state_n;
    len_sel_e          len_q;
    frame_t            frm;
    logic              go, load, dclr, dhit, dstep, fend, done_set;
    logic              buf_full;
    logic [WORD_W-1:0] buf_word;
    logic [DLY_W-1:0]  dlimit;

    assign go        = en_all && en_tx;
    assign wr_ready  = !buf_full;
    assign buf_empty = !buf_full;
    assign de        = (state != S_IDLE);
    assign frm       = make_frame(buf_word, len_q, par_on, par_odd);
    assign dstep     = os_tick && ((state == S_LEAD) || (state == S_TRAIL));
    assign dlimit    = (state == S_LEAD) ? lead_dly : trail_dly;

    rs485_len_hold u_len (
        .clk    (clk),
        .rst    (rst),
        .sel_in (len_sel),
        .sel_q  (len_q)
    );

    rs485_lag_count #(.DLY_W(DLY_W)) u_lag (
        .clk   (clk),
        .rst   (rst),
        .clr   (dclr),
        .step  (dstep),
        .limit (dlimit),
        .hit   (dhit)
    );

    rs485_bit_shift #(.OS(OS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .clear     (!go),
        .load      (load),
        .frm       (frm),
        .tick      (os_tick),
        .txd       (txd),
        .frame_end (fend)
    );

    always_comb begin
        state_n  = state;
        load     = 1'b0;
        dclr     = 1'b0;
        done_set = 1'b0;
        case (state)
            S_IDLE: begin
                if (buf_full) begin
                    state_n = S_LEAD;
                    dclr    = 1'b1;
                end
            end
            S_LEAD: begin
                if (os_tick && dhit) begin
                    load    = 1'b1;
                    state_n = S_SHIFT;
                end
            end
            S_SHIFT: begin
                if (fend) begin
                    if (buf_full) begin
                        load = 1'b1;
                    end else begin
                        state_n = S_TRAIL;
                        dclr    = 1'b1;
                    end
                end
            end
            S_TRAIL: begin
                if (os_tick) begin
                    if (buf_full) begin
                        load    = 1'b1;
                        state_n = S_SHIFT;
                    end else if (dhit) begin
                        state_n  = S_IDLE;
                        done_set = 1'b1;
                    end
                end
            end
            default: state_n = S_IDLE;
        endcase
        if (!go) begin
            state_n  = S_IDLE;
            load     = 1'b0;
            done_set = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            tx_done  <= 1'b0;
            buf_full <= 1'b0;
            buf_word <= '0;
        end else begin
            state   <= state_n;
            tx_done <= done_set;
            if (load) begin
                buf_full <= 1'b0;
            end else if (wr_valid && !buf_full) begin
                buf_full <= 1'b1;
                buf_word <= wr_data;
            end
        end
    end

    a_r1_gate: assert property (@(posedge clk) disable iff (rst)
        !go |=> !de);

    a_r9_idle_high: assert property (@(posedge clk) disable iff (rst)
        !de |-> txd);

    a_r2_lead_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == S_LEAD) |-> txd);

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    a_r11_done_release: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (!de && $past(de)));

    a_r12_one_slot: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> !wr_ready);

endmodule

// File: tb/rs485_tx_test.sv
module rs485_tx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       en_all = 1'b0;
    logic       en_tx = 1'b0;
    logic [1:0] len_sel = 2'b00;
    logic       par_on = 1'b0;
    logic       par_odd = 1'b0;
    logic [4:0] lead_dly = '0;
    logic [4:0] trail_dly = '0;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_data = '0;
    logic       wr_ready, txd, de, buf_empty, tx_done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int eff_len = 0;

    rs485_tx uut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .en_all(en_all), .en_tx(en_tx),
        .len_sel(len_sel), .par_on(par_on), .par_odd(par_odd),
        .lead_dly(lead_dly), .trail_dly(trail_dly),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .txd(txd), .de(de), .buf_empty(buf_empty), .tx_done(tx_done)
    );

    always #5 clk = ~clk;

    always @(negedge clk) os_tick <= rst ? 1'b0 : ~os_tick;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int nbits_of(input int code);
        if (code == 1) return 9;
        if (code == 2) return 7;
        return 8;
    endfunction

    function automatic logic [10:0] mk(input logic [8:0] d, input int nd,
                                       input bit pon, input bit podd);
        logic [10:0] f;
        logic [8:0]  low;
        int          p;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < nd; i++) f[i+1] = d[i];
        if (pon) begin
            low   = d & 9'((1 << (nd - 1)) - 1);
            p     = ($countones(low) % 2) ^ int'(podd);
            f[nd] = p[0];
        end
        return f;
    endfunction

    task automatic put(input logic [8:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(posedge clk);
        while (!wr_ready) @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic watch(input int K, input logic [10:0] f0, input logic [10:0] f1,
                         input int nd, input int L, input int T, input string tag);
        int nb = nd + 2;
        int total = 16 * nb * K;
        int n = 0;
        int m;
        int waitc = 0;
        int b;
        int exp_tx, exp_de, exp_dn;
        bit t;
        logic [10:0] fr;
        while (!de && waitc < 2000) begin
            @(posedge clk);
            #1;
            waitc++;
        end
        chk(de == 1'b1, {tag, " R2 de rise"}, int'(de), 1);
        while (1) begin
            @(posedge clk);
            t = os_tick;
            #1;
            if (!t) continue;
            n++;
            m = n - (L + 1);
            exp_dn = 0;
            if (m < 0) begin
                exp_de = 1; exp_tx = 1;
            end else if (m < total) begin
                fr     = ((m / (16 * nb)) == 0) ? f0 : f1;
                b      = (m % (16 * nb)) / 16;
                exp_tx = int'(fr[b]);
                exp_de = 1;
            end else if (m <= total + T) begin
                exp_de = 1; exp_tx = 1;
            end else begin
                exp_de = 0; exp_tx = 1; exp_dn = 1;
            end
            chk(int'(txd) == exp_tx, {tag, " R9 R4 txd"}, int'(txd), exp_tx);
            chk(int'(de) == exp_de, {tag, " R2 R3 R10 de"}, int'(de), exp_de);
            chk(int'(tx_done) == exp_dn, {tag, " R11 done"}, int'(tx_done), exp_dn);
            if (m >= total + T + 1) break;
        end
        @(posedge clk);
        #1;
        chk(tx_done == 1'b0, {tag, " R11 single pulse"}, int'(tx_done), 0);
        chk(buf_empty == 1'b1 && wr_ready == 1'b1, {tag, " R12 empty"}, int'(buf_empty), 1);
    endtask

    task automatic run(input int K, input logic [8:0] d0, input logic [8:0] d1,
                       input int code, input bit pon, input bit podd,
                       input int L, input int T, input string tag);
        int nd;
        logic [10:0] f0, f1;
        @(negedge clk);
        len_sel   = 2'(code);
        par_on    = pon;
        par_odd   = podd;
        lead_dly  = 5'(L);
        trail_dly = 5'(T);
        if (code != 3) eff_len = code;
        nd = nbits_of(eff_len);
        f0 = mk(d0, nd, pon, podd);
        f1 = mk(d1, nd, pon, podd);
        fork
            begin
                put(d0);
                if (K > 1) put(d1);
            end
            watch(K, f0, f1, nd, L, T, tag);
        join
    endtask

    initial begin
        int lv[4] = '{0, 1, 7, 31};
        logic [8:0] d0;
        repeat (3) @(posedge clk);
        #1;
        chk(de == 1'b0, "R1 reset de", int'(de), 0);
        chk(txd == 1'b1, "R9 reset txd", int'(txd), 1);
        chk(wr_ready == 1'b1, "R12 reset ready", int'(wr_ready), 1);
        chk(buf_empty == 1'b1, "R12 reset empty", int'(buf_empty), 1);
        chk(tx_done == 1'b0, "R11 reset done", int'(tx_done), 0);
        @(negedge clk);
        rst    = 1'b0;
        en_all = 1'b1;
        en_tx  = 1'b1;

        // lengths x parity modes, back-to-back pairs
        for (int code = 0; code < 3; code++) begin
            for (int pm = 0; pm < 3; pm++) begin
                d0 = 9'(37 * code + 91 * pm + 'h5A);
                run(2, d0, ~d0, code, pm != 0, pm == 2, 3, 2, "R5 R7 R8 R10 sweep");
            end
        end

        // lead and trail pairings
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                run(1, 9'h0A5, 9'h000, 0, 1'b0, 1'b0, lv[i], lv[j], "R2 R3 lag sweep");
            end
        end

        // reserved length code keeps 7-bit setting
        run(1, 9'h1B3, 9'h000, 2, 1'b0, 1'b0, 0, 0, "R5 seven");
        run(1, 9'h155, 9'h000, 3, 1'b0, 1'b0, 1, 1, "R6 rsvd code");
        run(1, 9'h1F0, 9'h000, 3, 1'b1, 1'b1, 2, 0, "R6 rsvd parity");

        // transmitter disabled with a word waiting
        @(negedge clk);
        en_tx     = 1'b0;
        len_sel   = 2'b00;
        eff_len   = 0;
        par_on    = 1'b0;
        lead_dly  = 5'd4;
        trail_dly = 5'd0;
        put(9'h0C3);
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            #1;
            chk(de == 1'b0, "R1 disabled de", int'(de), 0);
            chk(txd == 1'b1, "R1 disabled txd", int'(txd), 1);
        end
        chk(wr_ready == 1'b0, "R12 slot full ready", int'(wr_ready), 0);
        chk(buf_empty == 1'b0, "R12 slot full empty", int'(buf_empty), 0);
        @(negedge clk);
        en_tx = 1'b1;
        watch(1, mk(9'h0C3, 8, 1'b0, 1'b0), 11'h7FF, 8, 4, 0, "R1 resume");

        // global enable dropped mid-frame
        fork
            put(9'h0F0);
            begin
                while (!de) @(posedge clk);
                repeat (60) @(posedge clk);
            end
        join
        @(negedge clk);
        en_all = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            #1;
            chk(de == 1'b0, "R1 abort de", int'(de), 0);
            chk(txd == 1'b1, "R1 abort txd", int'(txd), 1);
            chk(tx_done == 1'b0, "R1 abort no done", int'(tx_done), 0);
        end
        @(negedge clk);
        en_all = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            #1;
            chk(de == 1'b0, "R1 nothing left", int'(de), 0);
        end
        chk(buf_empty == 1'b1, "R12 abort slot", int'(buf_empty), 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule